// File: doc/BRIEF.md
# Nth-Chance Clock Victim Selector

This block picks which physical frame to evict when a page fault needs room. It keeps three pieces of state per frame: a use flag, a dirty flag and a small counter of hand passes that found the frame idle. Software-side logic reports accesses through a reference port (read) and a write port. Both set the use flag, and the write port also sets the dirty flag. Raising the fault request starts a sweep. A single hand then visits frames in circular order, one per clock.

A recently used frame gets another chance: its use flag and counter are cleared and the hand moves on. An idle clean frame is evicted once its counter reaches the clean threshold `CLEAN_N`. An idle dirty frame instead triggers a write-back request when its counter reaches that threshold, so its contents are saved before eviction. It stays ineligible until the external agent signals completion, which makes the frame clean again. Dirty frames therefore need one more idle pass than clean ones. Only one write-back is outstanding at a time. The hand waits at a second dirty frame that needs saving until the channel frees.

Top module: `nchance_clock_victim`

## Requirements
- R1: After reset every frame is unused, clean and has a zero counter. The hand is at frame 0, and `sweeping`, `victim_valid` and `wb_req` are low.
- R2: A fault request seen while idle evaluates the frame under the hand at that same clock edge. While the sweep continues, the hand advances one frame per clock, wraps from frame NFRAMES-1 to frame 0, and finishes one frame past the victim.
- R3: When the hand finds a frame with its use flag set, it clears the use flag and the counter and does not evict that frame.
- R4: When the hand finds an unused clean frame whose incremented counter reaches `CLEAN_N`, that frame becomes the victim. `victim_valid` is high for the cycle after that edge, with `victim_frame` giving the frame index, and the sweep ends.
- R5: A victim frame is refilled: it becomes used and clean, and its counter becomes 0.
- R6: A pulse on `ref_valid` sets the use flag of `ref_frame`. A pulse on `wr_valid` sets both the use and dirty flags of `wr_frame`. These port updates override the hand's clearing in the same cycle.
- R7: When the hand finds an unused dirty frame whose incremented counter reaches `CLEAN_N`, and no write-back is outstanding, it raises `wb_req` with `wb_frame` set to that frame. Both are held until `wb_done` arrives.
- R8: While a write-back is outstanding, the hand stops at any other dirty frame that needs one. It does not advance and emits no victim until the outstanding write-back completes.
- R9: A dirty frame is never chosen as victim. When its write-back is still pending, the hand passes it with its counter incremented, saturating at `CLEAN_N`+1.
- R10: `wb_done` while `wb_req` is high clears the dirty flag of `wb_frame`, and `wb_req` is low in the next cycle. That frame is then evicted on the hand's next idle visit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | Read access to a frame |
| ref_frame | input | $clog2(NFRAMES) | Frame read |
| wr_valid | input | 1 | Write access to a frame |
| wr_frame | input | $clog2(NFRAMES) | Frame written |
| fault_req | input | 1 | Request a victim |
| sweeping | output | 1 | Hand is in a sweep |
| victim_valid | output | 1 | One-cycle victim strobe |
| victim_frame | output | $clog2(NFRAMES) | Chosen frame |
| wb_req | output | 1 | Write-back outstanding |
| wb_frame | output | $clog2(NFRAMES) | Frame being written back |
| wb_done | input | 1 | Write-back finished |

## Verification
The bench builds the block with NFRAMES=4 and CLEAN_N=1. Four frames keep every hand position and the wrap within a handful of cycles, so exact victim indices and sweep lengths can be predicted by hand. With all four frames dirty, the single write-back channel becomes the bottleneck. This lets the bench watch the hand stall at each frame in turn and see the write-back order 0, 1, 2, 3 before a clean victim appears. A dirty frame passed while its write-back is pending, and later evicted after completion, exercises the counter saturation.

// File: rtl/nchance_clock_victim.sv
module nchance_clock_victim #(
  parameter int NFRAMES = 16,
  parameter int CLEAN_N = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ref_valid,
  input  logic [$clog2(NFRAMES)-1:0] ref_frame,
  input  logic                       wr_valid,
  input  logic [$clog2(NFRAMES)-1:0] wr_frame,
  input  logic                       fault_req,
  output logic                       sweeping,
  output logic                       victim_valid,
  output logic [$clog2(NFRAMES)-1:0] victim_frame,
  output logic                       wb_req,
  output logic [$clog2(NFRAMES)-1:0] wb_frame,
  input  logic                       wb_done
);
  localparam int IW      = $clog2(NFRAMES);
  localparam int DIRTY_N = CLEAN_N + 1;
  localparam int CW      = $clog2(DIRTY_N + 1);
  localparam logic [IW-1:0] LAST = IW'(NFRAMES - 1);
  localparam logic [CW-1:0] CMAX = CW'(DIRTY_N);
  localparam logic [CW-1:0] CTHR = CW'(CLEAN_N);

  logic [NFRAMES-1:0] use_q, dirty_q;
  logic [CW-1:0]      cnt_q [NFRAMES];
  logic [IW-1:0]      hand;

  logic          cur_use, cur_dirty, pend_here, at_thr, act;
  logic          need_wb, stall, issue, pick;
  logic [CW-1:0] cur_cnt, cnt_inc;

  assign cur_use   = use_q[hand];
  assign cur_dirty = dirty_q[hand];
  assign cur_cnt   = cnt_q[hand];
  assign cnt_inc   = (cur_cnt == CMAX) ? CMAX : cur_cnt + 1'b1;
  assign at_thr    = cnt_inc >= CTHR;
  assign pend_here = wb_req && (wb_frame == hand);
  assign act       = sweeping || fault_req;

  assign need_wb = !cur_use && cur_dirty && at_thr && !pend_here;
  assign stall   = act && need_wb && wb_req;
  assign issue   = act && need_wb && !wb_req;
  assign pick    = act && !cur_use && !cur_dirty && at_thr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      use_q        <= '0;
      dirty_q      <= '0;
      for (int i = 0; i < NFRAMES; i++) cnt_q[i] <= '0;
      hand         <= '0;
      sweeping     <= 1'b0;
      victim_valid <= 1'b0;
      victim_frame <= '0;
      wb_req       <= 1'b0;
      wb_frame     <= '0;
    end else begin
      victim_valid <= pick;
      if (pick) victim_frame <= hand;

      if (act && !stall) begin
        hand     <= (hand == LAST) ? '0 : hand + 1'b1;
        sweeping <= !pick;
        if (cur_use) begin
          use_q[hand] <= 1'b0;
          cnt_q[hand] <= '0;
        end else if (pick) begin
          use_q[hand]   <= 1'b1;
          dirty_q[hand] <= 1'b0;
          cnt_q[hand]   <= '0;
        end else begin
          cnt_q[hand] <= cnt_inc;
        end
      end

      if (wb_req && wb_done) begin
        wb_req            <= 1'b0;
        dirty_q[wb_frame] <= 1'b0;
      end else if (issue) begin
        wb_req   <= 1'b1;
        wb_frame <= hand;
      end

      if (ref_valid) use_q[ref_frame] <= 1'b1;
      if (wr_valid) begin
        use_q[wr_frame]   <= 1'b1;
        dirty_q[wr_frame] <= 1'b1;
      end
    end
  end

  AST_WB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_done |=> wb_req && $stable(wb_frame)); // R7

  AST_WB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && wb_done |=> !wb_req); // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(hand) && !victim_valid); // R8

  AST_NO_PENDING_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> !(wb_req && wb_frame == victim_frame)); // R9

  AST_HAND_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(act) && !$past(stall) && $past(hand) == LAST |-> hand == '0); // R2

  always @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NFRAMES; i++)
        AST_CNT_SAT: assert (cnt_q[i] <= CMAX); // R9
    end
  end
endmodule

// File: tb/sim_nchance_clock_victim.sv
`timescale 1ns/1ps
module sim_nchance_clock_victim;
  localparam int NF = 4;
  localparam int IW = $clog2(NF);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_valid = 1'b0, wr_valid = 1'b0, fault_req = 1'b0, wb_done = 1'b0;
  logic [IW-1:0] ref_frame = '0, wr_frame = '0;
  logic          sweeping, victim_valid, wb_req;
  logic [IW-1:0] victim_frame, wb_frame;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  nchance_clock_victim #(.NFRAMES(NF), .CLEAN_N(1)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ref_valid(ref_valid), .ref_frame(ref_frame),
    .wr_valid(wr_valid), .wr_frame(wr_frame),
    .fault_req(fault_req), .sweeping(sweeping),
    .victim_valid(victim_valid), .victim_frame(victim_frame),
    .wb_req(wb_req), .wb_frame(wb_frame), .wb_done(wb_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ref_valid = 0; wr_valid = 0; fault_req = 0; wb_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic touch(input int f);
    @(negedge clk);
    ref_valid = 1'b1; ref_frame = IW'(f);
    @(negedge clk);
    ref_valid = 1'b0;
  endtask

  task automatic write(input int f);
    @(negedge clk);
    wr_valid = 1'b1; wr_frame = IW'(f);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic fault(output int vf, output int cyc);
    vf = -1; cyc = 0;
    @(negedge clk);
    fault_req = 1'b1;
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk);
      fault_req = 1'b0;
      if (victim_valid) begin
        vf = int'(victim_frame); cyc = i;
        break;
      end
    end
  endtask

  task automatic t_reset();
    do_reset();
    check(!sweeping, "R1 sweeping", sweeping, 0);
    check(!victim_valid, "R1 victim_valid", victim_valid, 0);
    check(!wb_req, "R1 wb_req", wb_req, 0);
  endtask

  task automatic t_second_chance();
    int vf, cyc;
    do_reset();
    fault(vf, cyc);
    check(vf == 0, "R4 first victim", vf, 0);
    check(cyc == 1, "R2 same-edge evaluation", cyc, 1);
    @(negedge clk);
    check(!victim_valid, "R4 single-cycle strobe", victim_valid, 0);
    fault(vf, cyc);
    check(vf == 1, "R2 hand past victim", vf, 1);
    touch(2);
    touch(3);
    fault(vf, cyc);
    check(vf == 2, "R3 R5 R6 victim after wrap", vf, 2);
    check(cyc == 5, "R2 R3 one frame per cycle", cyc, 5);
    check(!sweeping, "R4 sweep ends", sweeping, 0);
  endtask

  task automatic t_dirty_path();
    int vf, cyc;
    do_reset();
    write(0);
    touch(1); touch(2); touch(3);
    fault(vf, cyc);
    check(vf == 1, "R7 clean frame after dirty", vf, 1);
    check(cyc == 6, "R7 sweep length", cyc, 6);
    check(wb_req, "R7 wb_req raised", wb_req, 1);
    check(wb_frame == 0, "R7 wb_frame", wb_frame, 0);
    touch(2); touch(3);
    fault(vf, cyc);
    check(vf == 2, "R9 pending dirty skipped", vf, 2);
    check(cyc == 5, "R9 sweep length", cyc, 5);
    check(wb_req && wb_frame == 0, "R7 wb held", wb_req, 1);
    @(negedge clk);
    wb_done = 1'b1;
    @(negedge clk);
    wb_done = 1'b0;
    check(!wb_req, "R10 wb_req dropped", wb_req, 0);
    touch(3);
    fault(vf, cyc);
    check(vf == 0, "R10 cleaned frame evicted", vf, 0);
    check(cyc == 2, "R10 sweep length", cyc, 2);
  endtask

  task automatic t_stall();
    int order[4];
    int nseen = 0, last = -1, hold = 0, vf = -1;
    bit got = 0;
    do_reset();
    write(0); write(1); write(2); write(3);
    @(negedge clk);
    fault_req = 1'b1;
    for (int i = 0; i < 400 && !got; i++) begin
      @(negedge clk);
      fault_req = 1'b0;
      if (victim_valid) begin
        got = 1; vf = int'(victim_frame);
      end else if (wb_done) begin
        wb_done = 1'b0; hold = 0;
      end else if (wb_req) begin
        if (int'(wb_frame) != last) begin
          if (nseen < 4) order[nseen] = int'(wb_frame);
          nseen++;
          last = int'(wb_frame);
        end
        hold++;
        if (hold == 10) begin
          if (nseen == 1) check(sweeping, "R8 hand waiting", sweeping, 1);
          wb_done = 1'b1;
        end
      end
    end
    check(nseen == 4, "R8 write-back count", nseen, 4);
    for (int k = 0; k < 4; k++)
      if (k < nseen) check(order[k] == k, "R8 write-back order", order[k], k);
    check(vf == 0, "R10 victim after stalls", vf, 0);
  endtask

  initial begin
    #(8ns * 100000);
    fails++; tests++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_second_chance();
    t_dirty_path();
    t_stall();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule